// File: doc/BRIEF.md
# Multilevel Read Threshold Sweep

This block reads a resistive memory cell that stores one or two bits, using one comparator. It does not use a bank of parallel comparators. It drives a digital reference code to an external reference generator and waits a programmable settling time. It then strobes the comparator, which reports whether the cell conductance is above the reference. The reference starts at the upper threshold of the lowest level and climbs one level per step. The stored level is the first step at which the comparator answers 0. If the comparator never answers 0, the cell holds the highest level.

A read starts with a one-cycle request. The bits-per-cell setting and the settling count are captured when the read starts. The sweep ends at the first 0 from the comparator. The decoded level is then presented with a valid flag that lasts one cycle.

Top module: `multilevel_read_sweep`

## Requirements
- R1: After reset, refCode, levelOut, levelValid and cmpEn are all 0.
- R2: Sample number k of a read (k counted from 0) is taken with refCode equal to threshold entry k. Entry k sits at thrTable bits [k*REF_W +: REF_W]. The steps use k = 0, 1, 2 in increasing order.
- R3: Before every cycle with cmpEn high there are exactly settleCycles+1 cycles with cmpEn low. These are counted from the cycle after the accepted request, or from the previous cmpEn cycle. refCode does not change during that wait or during the cmpEn cycle.
- R4: The decoded level is the index of the first sample at which cmpIn is 0. cmpIn = 1 means the conductance is above the reference.
- R5: If every sample returns 1, the decoded level is the highest level: 3 at two bits per cell, 1 at one bit per cell.
- R6: bitsSel = 0 selects one bit per cell. Only threshold entry 0 is tested, and the level is 0 or 1. bitsSel = 1 selects two bits per cell. Up to three entries are tested, and the level is in 0..3.
- R7: The sweep stops at the first 0. No further cmpEn pulse occurs in that read.
- R8: levelValid is high for exactly one cycle per read and never in the same cycle as cmpEn. levelOut carries the result in that cycle and holds it until the next result.
- R9: A request that arrives while a read is in progress, including its valid cycle, is ignored. bitsSel and settleCycles changes during a read do not affect that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| readReq | input | 1 | Read request, accepted only when idle |
| bitsSel | input | 1 | Bits per cell minus one (0: 1 bit, 1: 2 bits) |
| settleCycles | input | 4 | Extra settling cycles after each reference change |
| thrTable | input | 24 | Packed upper-threshold codes, entry k at [k*8 +: 8] |
| cmpIn | input | 1 | Comparator result, 1 when cell is above reference |
| refCode | output | 8 | Reference code to the external generator |
| cmpEn | output | 1 | Comparator sample strobe |
| levelOut | output | 2 | Decoded level |
| levelValid | output | 1 | One-cycle result flag |

## Verification
A fresh request can arrive in the very cycle that the previous result is reported. Two events can then share a cycle: the end of one read and the attempt to start another. The bench drives readReq high exactly when it sees levelValid. It then confirms that no sample strobe follows and that the reference and level stay unchanged for several cycles. In a separate case, the bench pulses a request and flips the mode and settle count in the middle of a sweep. It checks that the number of steps, their spacing and the result still follow the settings captured at the start.

// File: rtl/mlrs_pkg.sv
package mlrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_DONE   = 2'd3
  } sweepState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;      // capture settings, load first threshold
    logic countDown;  // decrement settle counter
    logic advance;    // move to next threshold
    logic finishHit;  // record current index as level
    logic finishTop;  // record highest level
  } sweepStrobe_t;

endpackage

// File: rtl/mlrs_ctrl.sv
module mlrs_ctrl
  import mlrs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         readReq,
  input  logic         cmpIn,
  input  logic         cntZero,
  input  logic         lastStep,
  output sweepStrobe_t strobe,
  output logic         cmpEn,
  output logic         levelValid
);

  sweepState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (readReq) begin
          strobe.start = 1'b1;
          nextState    = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (cntZero) nextState = ST_SAMPLE;
        else         strobe.countDown = 1'b1;
      end
      ST_SAMPLE: begin
        if (!cmpIn) begin
          strobe.finishHit = 1'b1;
          nextState        = ST_DONE;
        end else if (lastStep) begin
          strobe.finishTop = 1'b1;
          nextState        = ST_DONE;
        end else begin
          strobe.advance = 1'b1;
          nextState      = ST_SETTLE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign cmpEn      = (state == ST_SAMPLE);
  assign levelValid = (state == ST_DONE);

endmodule

// File: rtl/mlrs_datapath.sv
module mlrs_datapath
  import mlrs_pkg::*;
#(
  parameter int REF_W   = 8,
  parameter int MAX_BPC = 2,
  parameter int SET_W   = 4,
  localparam int NUM_LVL = 1 << MAX_BPC,
  localparam int NUM_THR = NUM_LVL - 1,
  localparam int LVL_W   = MAX_BPC,
  localparam int BPC_W   = (MAX_BPC > 1) ? $clog2(MAX_BPC) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  sweepStrobe_t             strobe,
  input  logic [NUM_THR*REF_W-1:0] thrTable,
  input  logic [BPC_W-1:0]         bitsSel,
  input  logic [SET_W-1:0]         settleCycles,
  output logic [REF_W-1:0]         refCode,
  output logic [LVL_W-1:0]         levelOut,
  output logic                     cntZero,
  output logic                     lastStep,
  output logic [BPC_W-1:0]         modeLat
);

  logic [REF_W-1:0] thrArr [NUM_LVL];
  logic [LVL_W-1:0] idx;
  logic [LVL_W-1:0] nextIdx;
  logic [LVL_W-1:0] topLevel;
  logic [SET_W-1:0] cnt;
  logic [SET_W-1:0] settleLat;

  // Unpack thresholds; the slot above the last threshold is never selected
  for (genvar k = 0; k < NUM_LVL; k++) begin : g_thr
    if (k < NUM_THR) begin : g_real
      assign thrArr[k] = thrTable[k*REF_W +: REF_W];
    end else begin : g_pad
      assign thrArr[k] = '0;
    end
  end

  function automatic logic [LVL_W-1:0] topOf(input logic [BPC_W-1:0] sel);
    int n;
    n = int'(sel) + 1;
    if (n > MAX_BPC) n = MAX_BPC;
    return LVL_W'((1 << n) - 1);
  endfunction

  assign topLevel = topOf(modeLat);
  assign nextIdx  = idx + LVL_W'(1);
  assign lastStep = (idx == topLevel - LVL_W'(1));
  assign cntZero  = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= '0;
      refCode   <= '0;
      cnt       <= '0;
      settleLat <= '0;
      modeLat   <= '0;
      levelOut  <= '0;
    end else begin
      if (strobe.start) begin
        idx       <= '0;
        refCode   <= thrArr[0];
        cnt       <= settleCycles;
        settleLat <= settleCycles;
        modeLat   <= bitsSel;
      end
      if (strobe.countDown) cnt <= cnt - SET_W'(1);
      if (strobe.advance) begin
        idx     <= nextIdx;
        refCode <= thrArr[nextIdx];
        cnt     <= settleLat;
      end
      if (strobe.finishHit) levelOut <= idx;
      if (strobe.finishTop) levelOut <= topLevel;
    end
  end

endmodule

// File: rtl/multilevel_read_sweep.sv
module multilevel_read_sweep
  import mlrs_pkg::*;
#(
  parameter int REF_W   = 8,
  parameter int MAX_BPC = 2,
  parameter int SET_W   = 4,
  localparam int NUM_THR = (1 << MAX_BPC) - 1,
  localparam int LVL_W   = MAX_BPC,
  localparam int BPC_W   = (MAX_BPC > 1) ? $clog2(MAX_BPC) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     readReq,
  input  logic [BPC_W-1:0]         bitsSel,
  input  logic [SET_W-1:0]         settleCycles,
  input  logic [NUM_THR*REF_W-1:0] thrTable,
  input  logic                     cmpIn,
  output logic [REF_W-1:0]         refCode,
  output logic                     cmpEn,
  output logic [LVL_W-1:0]         levelOut,
  output logic                     levelValid
);

  sweepStrobe_t     strobe;
  logic             cntZero;
  logic             lastStep;
  logic [BPC_W-1:0] modeLat;

  mlrs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .readReq    (readReq),
    .cmpIn      (cmpIn),
    .cntZero    (cntZero),
    .lastStep   (lastStep),
    .strobe     (strobe),
    .cmpEn      (cmpEn),
    .levelValid (levelValid)
  );

  mlrs_datapath #(
    .REF_W   (REF_W),
    .MAX_BPC (MAX_BPC),
    .SET_W   (SET_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .thrTable     (thrTable),
    .bitsSel      (bitsSel),
    .settleCycles (settleCycles),
    .refCode      (refCode),
    .levelOut     (levelOut),
    .cntZero      (cntZero),
    .lastStep     (lastStep),
    .modeLat      (modeLat)
  );

endmodule

// File: rtl/mlrs_checker.sv
module mlrs_checker #(
  parameter int REF_W = 8,
  parameter int LVL_W = 2,
  parameter int BPC_W = 1
)(
  input logic             clk,
  input logic             rstN,
  input logic             cmpEn,
  input logic             levelValid,
  input logic [REF_W-1:0] refCode,
  input logic [LVL_W-1:0] levelOut,
  input logic [BPC_W-1:0] modeLat
);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> !levelValid);

  assert_valid_not_sample_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(levelValid && cmpEn));

  assert_ref_settled_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmpEn |-> $stable(refCode));

  assert_sample_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmpEn |=> !cmpEn);

  assert_onebit_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && modeLat == '0) |-> (levelOut <= LVL_W'(1)));

  assert_stop_after_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> !cmpEn);

endmodule

bind multilevel_read_sweep mlrs_checker #(
  .REF_W (REF_W),
  .LVL_W (LVL_W),
  .BPC_W (BPC_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmpEn      (cmpEn),
  .levelValid (levelValid),
  .refCode    (refCode),
  .levelOut   (levelOut),
  .modeLat    (modeLat)
);

// File: tb/tb_multilevel_read_sweep.sv
`timescale 1ns/1ps
module tb_multilevel_read_sweep;

  localparam int REF_W = 8;
  localparam int SET_W = 4;
  localparam int NTHR  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              readReq = 1'b0;
  logic [0:0]        bitsSel = 1'b0;
  logic [SET_W-1:0]  settleCycles = '0;
  logic [NTHR*REF_W-1:0] thrTable = '0;
  logic              cmpIn;
  logic [REF_W-1:0]  refCode;
  logic              cmpEn;
  logic [1:0]        levelOut;
  logic              levelValid;
  logic [REF_W-1:0]  cellG = '0;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  // Comparator model: 1 when the cell is above the reference
  always_comb cmpIn = (cellG > refCode);

  multilevel_read_sweep dut (
    .clk(clk), .rstN(rstN), .readReq(readReq), .bitsSel(bitsSel),
    .settleCycles(settleCycles), .thrTable(thrTable), .cmpIn(cmpIn),
    .refCode(refCode), .cmpEn(cmpEn), .levelOut(levelOut), .levelValid(levelValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [REF_W-1:0] thrOf(input int k);
    return thrTable[k*REF_W +: REF_W];
  endfunction

  function automatic int expLevel(input logic [REF_W-1:0] g, input int mode);
    int top = (mode == 0) ? 1 : 3;
    for (int k = 0; k < top; k++)
      if (!(g > thrOf(k))) return k;
    return top;
  endfunction

  function automatic int expSteps(input logic [REF_W-1:0] g, input int mode);
    int top = (mode == 0) ? 1 : 3;
    int lv = expLevel(g, mode);
    return (lv == top) ? top : lv + 1;
  endfunction

  // inject: 1 = request and setting changes mid-sweep, 2 = request in valid cycle
  task automatic doRead(input logic [REF_W-1:0] g, input int mode, input int settle, input int inject);
    int step = 0, low = 0, cyc = 0;
    bit spacingOk = 1, orderOk = 1, gotValid = 0;
    int eLvl = expLevel(g, mode);
    int eSteps = expSteps(g, mode);
    int lastLvl;
    cellG = g;
    bitsSel = mode[0];
    settleCycles = SET_W'(settle);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    while (cyc < 200) begin
      cyc++;
      if (levelValid) begin
        gotValid = 1;
        break;
      end else if (cmpEn) begin
        if (low != settle + 1) spacingOk = 0;
        if (step >= NTHR || refCode != thrOf(step)) orderOk = 0;
        step++;
        low = 0;
      end else low++;
      if (inject == 1 && step == 1 && low == 1) begin
        readReq = 1'b1;
        bitsSel = ~bitsSel;
        settleCycles = settleCycles + SET_W'(3);
      end else readReq = 1'b0;
      @(negedge clk);
    end
    readReq = 1'b0;
    check(gotValid, "R8 result flag seen", gotValid, 1);
    check(spacingOk, "R3 settle spacing", spacingOk, 1);
    check(orderOk, "R2 reference order", orderOk, 1);
    check(step == eSteps, "R7/R6 sample count", step, eSteps);
    check(levelOut == eLvl, (eLvl == ((mode == 0) ? 1 : 3)) ? "R5 top level" : "R4 decoded level",
          levelOut, eLvl);
    lastLvl = levelOut;
    if (inject == 2) readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    check(!levelValid && !cmpEn, "R8 valid one cycle", levelValid, 0);
    if (inject == 2) begin
      bit quiet = 1;
      for (int i = 0; i < settle + 4; i++) begin
        if (cmpEn || levelValid || levelOut != lastLvl) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R9 request in valid cycle ignored", quiet, 1);
    end
    check(levelOut == lastLvl, "R8 level holds", levelOut, lastLvl);
    bitsSel = mode[0];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(refCode == 0 && levelOut == 0 && !levelValid && !cmpEn, "R1 reset outputs",
          {refCode, levelOut, levelValid, cmpEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(refCode == 0 && !cmpEn && !levelValid, "R1 idle after reset", refCode, 0);

    thrTable = {8'd180, 8'd120, 8'd60};
    doRead(8'd10, 1, 0, 0);    // R4 level 0
    doRead(8'd100, 1, 2, 0);   // R4 level 1
    doRead(8'd150, 1, 15, 0);  // R4 level 2
    doRead(8'd255, 1, 1, 0);   // R5 top at two bits
    doRead(8'd60, 1, 0, 0);    // R4 equal to threshold -> 0
    doRead(8'd61, 1, 0, 0);    // R4 just above
    doRead(8'd30, 0, 3, 0);    // R6 one bit, level 0
    doRead(8'd250, 0, 3, 0);   // R6/R5 one bit top
    doRead(8'd150, 1, 2, 1);   // R9 mid-sweep request and setting changes
    doRead(8'd90, 0, 1, 1);    // R9 at one bit
    doRead(8'd200, 1, 0, 2);   // R9 request in the valid cycle

    for (int n = 0; n < 40; n++) begin
      thrTable = {8'($urandom), 8'($urandom), 8'($urandom)};
      doRead(8'($urandom), int'($urandom % 2), int'($urandom % 6), int'($urandom % 3));
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule